// File: doc/BRIEF.md
# Windowed Track-Multiplicity Trigger

This block counts hit pulses from four detector stations in every half-sector of a detector arm. All inputs are synchronous to the bunch clock. A window counter divides time into accumulation windows of programmable length. During a window, each half-sector/station pair holds a saturating hit counter. When the window closes, the counters are copied into a snapshot and cleared, so the next window starts at once with no dead time.

From the snapshot, each half-sector decides whether it holds a track candidate. Two conditions take part:

- a coincidence condition: enough stations saw at least one hit;
- a threshold condition: enough stations reached a minimum hit count.

A mode bit combines these two conditions with AND or with OR. Each sector is a pair of half-sectors and adds at most one track to the multiplicity. The sector count is compared against a programmable threshold, and the result leaves the block as a registered single-clock trigger pulse.

All settings are loaded from a set of configuration inputs on a single write strobe, normally before a run. A write also restarts the window and discards any decision still in flight.

Top module: `mult_trig`

## Requirements
- R1: Hit input bit `h*4+s` is station `s` (0..3) of half-sector `h`. Every window clock where that bit is high adds one to the pair's counter. This includes the window's final clock. Counters start from zero in every window.
- R2: A window lasts `cfg_win_len` clocks, and values 0 and 1 are treated as 2. The first window after a configuration write starts on the clock that follows the write edge. Windows then follow each other back to back.
- R3: A hit counter holds at its maximum value, 2^CNT_W-1, and does not wrap.
- R4: In a half-sector, the coincidence condition holds when the number of stations with a count of at least 1 is at least `cfg_stn_req`. The threshold condition holds when the number of stations with a count of at least `cfg_hit_min` is at least `cfg_stn_req`.
- R5: With `cfg_or_mode`=0, a half-sector flags a track when both conditions of R4 hold. With `cfg_or_mode`=1, either condition is enough.
- R6: Sector `k` is made of half-sectors `2k` and `2k+1`. It adds one track when either or both of them flag.
- R7: The trigger fires for a window when the sector track total is at least `cfg_trk_thr`.
- R8: `trig_o` is a one-clock pulse. It is high after the second rising edge that follows the edge sampling the window's last hits.
- R9: A clock edge with `cfg_we` high loads all settings and restarts the window. It also keeps `trig_o` low for the next two cycles.
- R10: `dbg_stn_req_o` shows the stored station requirement from the edge of the write onward.
- R11: After reset, `trig_o` is low and the stored settings are: window 7, station requirement 3, minimum hits 1, track threshold 5, AND mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_win_len | input | WIN_W | Window length in clocks |
| cfg_stn_req | input | 3 | Required station count |
| cfg_hit_min | input | CNT_W | Minimum hits for a station to count toward the threshold condition |
| cfg_trk_thr | input | TRK_W | Track-count threshold |
| cfg_or_mode | input | 1 | 0 = AND, 1 = OR combination |
| hit_i | input | 8*N_SECT | Hit pulses, bit h*4+s |
| trig_o | output | 1 | Trigger pulse |
| dbg_stn_req_o | output | 3 | Stored station requirement |

## Verification
The trigger for a window of n clocks that starts after a write is due after edge n+2. The bench counts edges from the write edge and samples on the falling edge that follows. It also samples after edges n+1 and n+3, where the output must be low, so an early, late or stretched pulse is caught. The debug output is checked right after the write edge. The flush behaviour is checked by placing a write one or two cycles after the window's last edge and observing that no pulse appears.

// File: rtl/mt_pkg.sv
package mt_pkg;
  localparam int NUM_STN = 4;
  localparam int REQ_W   = 3;

  typedef enum logic {
    COMB_AND = 1'b0,
    COMB_OR  = 1'b1
  } comb_e;
endpackage

// File: rtl/mt_cfg_bank.sv
module mt_cfg_bank
  import mt_pkg::*;
#(
  parameter int WIN_W = 4,
  parameter int CNT_W = 3,
  parameter int TRK_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [WIN_W-1:0] cfg_win_len,
  input  logic [REQ_W-1:0] cfg_stn_req,
  input  logic [CNT_W-1:0] cfg_hit_min,
  input  logic [TRK_W-1:0] cfg_trk_thr,
  input  logic             cfg_or_mode,
  output logic [WIN_W-1:0] win_len_q,
  output logic [REQ_W-1:0] stn_req_q,
  output logic [CNT_W-1:0] hit_min_q,
  output logic [TRK_W-1:0] trk_thr_q,
  output comb_e            comb_q
);
  logic [WIN_W-1:0] win_len_d;
  logic [REQ_W-1:0] stn_req_d;
  logic [CNT_W-1:0] hit_min_d;
  logic [TRK_W-1:0] trk_thr_d;
  comb_e            comb_d;

  always_comb begin
    win_len_d = win_len_q;
    stn_req_d = stn_req_q;
    hit_min_d = hit_min_q;
    trk_thr_d = trk_thr_q;
    comb_d    = comb_q;
    if (cfg_we) begin
      win_len_d = cfg_win_len;
      stn_req_d = cfg_stn_req;
      hit_min_d = cfg_hit_min;
      trk_thr_d = cfg_trk_thr;
      comb_d    = comb_e'(cfg_or_mode);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_len_q <= WIN_W'(7);
      stn_req_q <= REQ_W'(3);
      hit_min_q <= CNT_W'(1);
      trk_thr_q <= TRK_W'(5);
      comb_q    <= COMB_AND;
    end else if (cfg_we) begin
      win_len_q <= win_len_d;
      stn_req_q <= stn_req_d;
      hit_min_q <= hit_min_d;
      trk_thr_q <= trk_thr_d;
      comb_q    <= comb_d;
    end
  end
endmodule

// File: rtl/mt_hit_accum.sv
module mt_hit_accum
  import mt_pkg::*;
#(
  parameter int N_HALF = 16,
  parameter int WIN_W  = 4,
  parameter int CNT_W  = 3
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cfg_we,
  input  logic [N_HALF*NUM_STN-1:0]         hit_i,
  input  logic [WIN_W-1:0]                  win_len_q,
  output logic [N_HALF*NUM_STN-1:0][CNT_W-1:0] snap_q,
  output logic                              snap_vld_q
);
  localparam int               N_CNT   = N_HALF * NUM_STN;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [N_CNT-1:0][CNT_W-1:0] cnt_q, cnt_d, cnt_sum, snap_d;
  logic [WIN_W-1:0]            wcnt_q, wcnt_d, eff_last;
  logic                        last, snap_en, snap_vld_d;

  assign eff_last = (win_len_q < WIN_W'(2)) ? WIN_W'(1) : (win_len_q - WIN_W'(1));
  assign last     = (wcnt_q == eff_last);
  assign snap_en  = last && !cfg_we;

  always_comb begin
    for (int i = 0; i < N_CNT; i++) begin
      cnt_sum[i] = (hit_i[i] && (cnt_q[i] != CNT_MAX)) ? cnt_q[i] + CNT_W'(1) : cnt_q[i];
    end
  end

  always_comb begin
    snap_d     = snap_en ? cnt_sum : snap_q;
    snap_vld_d = snap_en;
    if (cfg_we || last) begin
      wcnt_d = '0;
      cnt_d  = '0;
    end else begin
      wcnt_d = wcnt_q + WIN_W'(1);
      cnt_d  = cnt_sum;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q     <= '0;
      cnt_q      <= '0;
      snap_vld_q <= 1'b0;
    end else begin
      wcnt_q     <= wcnt_d;
      cnt_q      <= cnt_d;
      snap_vld_q <= snap_vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       snap_q <= '0;
    else if (snap_en) snap_q <= snap_d;
  end

  // R2: window counter never passes the effective last position
  p_win_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt_q <= eff_last);

  generate
    for (genvar g = 0; g < N_CNT; g++) begin : g_sat
      // R3: a full counter keeps its value while the window continues
      p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q[g] == CNT_MAX && !cfg_we && !last) |=> (cnt_q[g] == CNT_MAX));
    end
  endgenerate
endmodule

// File: rtl/mt_hsec_flag.sv
module mt_hsec_flag
  import mt_pkg::*;
#(
  parameter int N_HALF = 16,
  parameter int CNT_W  = 3
) (
  input  logic [N_HALF*NUM_STN-1:0][CNT_W-1:0] snap_i,
  input  logic [REQ_W-1:0]                     stn_req_q,
  input  logic [CNT_W-1:0]                     hit_min_q,
  input  comb_e                                comb_q,
  output logic [N_HALF-1:0]                    flag_o
);
  generate
    for (genvar h = 0; h < N_HALF; h++) begin : g_hs
      logic [REQ_W-1:0] any_n, strong_n;
      logic             coinc, thresh;

      always_comb begin
        any_n    = '0;
        strong_n = '0;
        for (int s = 0; s < NUM_STN; s++) begin
          if (snap_i[h*NUM_STN+s] != '0)        any_n    = any_n + REQ_W'(1);
          if (snap_i[h*NUM_STN+s] >= hit_min_q) strong_n = strong_n + REQ_W'(1);
        end
      end

      assign coinc     = (any_n >= stn_req_q);
      assign thresh    = (strong_n >= stn_req_q);
      assign flag_o[h] = (comb_q == COMB_OR) ? (coinc || thresh) : (coinc && thresh);
    end
  endgenerate
endmodule

// File: rtl/mt_trk_count.sv
module mt_trk_count #(
  parameter int N_SECT = 8,
  parameter int TRK_W  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [2*N_SECT-1:0] flag_i,
  input  logic                snap_vld_i,
  input  logic [TRK_W-1:0]    trk_thr_q,
  output logic                trig_o
);
  logic [N_SECT-1:0] sect;
  logic [TRK_W-1:0]  total;
  logic              dec_q, dec_d, trig_q, trig_d;

  generate
    for (genvar k = 0; k < N_SECT; k++) begin : g_sect
      assign sect[k] = flag_i[2*k] | flag_i[2*k+1];
    end
  endgenerate

  always_comb begin
    total = '0;
    for (int k = 0; k < N_SECT; k++) total = total + TRK_W'(sect[k]);
  end

  always_comb begin
    dec_d  = snap_vld_i && !cfg_we && (total >= trk_thr_q);
    trig_d = dec_q && !cfg_we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_q  <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      dec_q  <= dec_d;
      trig_q <= trig_d;
    end
  end

  assign trig_o = trig_q;

  // R8: single-clock pulse
  p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trig_q |=> !trig_q);
  // R8: pulse follows a closed window by two edges
  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trig_q |-> $past(snap_vld_i, 2));
  // R9: a write keeps the output quiet
  p_cfg_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> !trig_q);
endmodule

// File: rtl/mult_trig.sv
module mult_trig
  import mt_pkg::*;
#(
  parameter int N_SECT = 8,
  parameter int WIN_W  = 4,
  parameter int CNT_W  = 3,
  localparam int N_HALF = 2 * N_SECT,
  localparam int N_CNT  = N_HALF * NUM_STN,
  localparam int TRK_W  = $clog2(N_SECT + 1) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [WIN_W-1:0] cfg_win_len,
  input  logic [2:0]       cfg_stn_req,
  input  logic [CNT_W-1:0] cfg_hit_min,
  input  logic [TRK_W-1:0] cfg_trk_thr,
  input  logic             cfg_or_mode,
  input  logic [N_CNT-1:0] hit_i,
  output logic             trig_o,
  output logic [2:0]       dbg_stn_req_o
);
  logic rst_meta_q, rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_s_n    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_s_n    <= rst_meta_q;
    end
  end

  logic [WIN_W-1:0]            win_len_q;
  logic [REQ_W-1:0]            stn_req_q;
  logic [CNT_W-1:0]            hit_min_q;
  logic [TRK_W-1:0]            trk_thr_q;
  comb_e                       comb_q;
  logic [N_CNT-1:0][CNT_W-1:0] snap;
  logic                        snap_vld;
  logic [N_HALF-1:0]           flag;

  mt_cfg_bank #(.WIN_W(WIN_W), .CNT_W(CNT_W), .TRK_W(TRK_W)) u_cfg (
    .clk(clk), .rst_n(rst_s_n), .cfg_we(cfg_we),
    .cfg_win_len(cfg_win_len), .cfg_stn_req(cfg_stn_req),
    .cfg_hit_min(cfg_hit_min), .cfg_trk_thr(cfg_trk_thr),
    .cfg_or_mode(cfg_or_mode),
    .win_len_q(win_len_q), .stn_req_q(stn_req_q), .hit_min_q(hit_min_q),
    .trk_thr_q(trk_thr_q), .comb_q(comb_q)
  );

  mt_hit_accum #(.N_HALF(N_HALF), .WIN_W(WIN_W), .CNT_W(CNT_W)) u_acc (
    .clk(clk), .rst_n(rst_s_n), .cfg_we(cfg_we), .hit_i(hit_i),
    .win_len_q(win_len_q), .snap_q(snap), .snap_vld_q(snap_vld)
  );

  mt_hsec_flag #(.N_HALF(N_HALF), .CNT_W(CNT_W)) u_flag (
    .snap_i(snap), .stn_req_q(stn_req_q), .hit_min_q(hit_min_q),
    .comb_q(comb_q), .flag_o(flag)
  );

  mt_trk_count #(.N_SECT(N_SECT), .TRK_W(TRK_W)) u_trk (
    .clk(clk), .rst_n(rst_s_n), .cfg_we(cfg_we), .flag_i(flag),
    .snap_vld_i(snap_vld), .trk_thr_q(trk_thr_q), .trig_o(trig_o)
  );

  assign dbg_stn_req_o = stn_req_q;

  // R10: debug output follows the written requirement
  p_dbg_follow_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    cfg_we |=> (dbg_stn_req_o == $past(cfg_stn_req)));
endmodule

// File: tb/sim_mult_trig.sv
module sim_mult_trig;
  localparam int N_SECT = 8;
  localparam int WIN_W  = 4;
  localparam int CNT_W  = 3;
  localparam int N_HALF = 2 * N_SECT;
  localparam int N_CNT  = N_HALF * 4;
  localparam int TRK_W  = $clog2(N_SECT + 1) + 1;
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cfg_we;
  logic [WIN_W-1:0] cfg_win_len;
  logic [2:0]       cfg_stn_req;
  logic [CNT_W-1:0] cfg_hit_min;
  logic [TRK_W-1:0] cfg_trk_thr;
  logic             cfg_or_mode;
  logic [N_CNT-1:0] hit_i;
  logic             trig_o;
  logic [2:0]       dbg_stn_req_o;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [N_CNT-1:0] stim [0:15];

  always #4ns clk = ~clk;

  mult_trig #(.N_SECT(N_SECT), .WIN_W(WIN_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_win_len(cfg_win_len),
    .cfg_stn_req(cfg_stn_req), .cfg_hit_min(cfg_hit_min),
    .cfg_trk_thr(cfg_trk_thr), .cfg_or_mode(cfg_or_mode),
    .hit_i(hit_i), .trig_o(trig_o), .dbg_stn_req_o(dbg_stn_req_o)
  );

  task automatic chk(input int act, input int exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit predict(input int n);
    int cnt [N_HALF][4];
    int anyn, strn, total;
    bit co, th, f0, f1;
    for (int h = 0; h < N_HALF; h++)
      for (int s = 0; s < 4; s++) cnt[h][s] = 0;
    for (int c = 0; c < n; c++)
      for (int h = 0; h < N_HALF; h++)
        for (int s = 0; s < 4; s++)
          if (stim[c][h*4+s] && cnt[h][s] < CMAX) cnt[h][s]++;
    total = 0;
    for (int k = 0; k < N_SECT; k++) begin
      f0 = 0; f1 = 0;
      for (int j = 0; j < 2; j++) begin
        anyn = 0; strn = 0;
        for (int s = 0; s < 4; s++) begin
          if (cnt[2*k+j][s] >= 1) anyn++;
          if (cnt[2*k+j][s] >= int'(cfg_hit_min)) strn++;
        end
        co = (anyn >= int'(cfg_stn_req));
        th = (strn >= int'(cfg_stn_req));
        if (j == 0) f0 = cfg_or_mode ? (co | th) : (co & th);
        else        f1 = cfg_or_mode ? (co | th) : (co & th);
      end
      if (f0 | f1) total++;
    end
    return total >= int'(cfg_trk_thr);
  endfunction

  task automatic clr_stim();
    for (int c = 0; c < 16; c++) stim[c] = '0;
  endtask

  task automatic cfg_write(input int win, input int req, input int hmin,
                           input int thr, input bit orm);
    @(negedge clk);
    cfg_win_len = WIN_W'(win);
    cfg_stn_req = 3'(req);
    cfg_hit_min = CNT_W'(hmin);
    cfg_trk_thr = TRK_W'(thr);
    cfg_or_mode = orm;
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    chk(dbg_stn_req_o, req, "R10 debug requirement");
  endtask

  // drives n window clocks, then checks edges n+1, n+2, n+3
  task automatic run_win(input int n, input int expect_fire, input string req);
    int exp;
    for (int c = 0; c < n; c++) begin
      hit_i = stim[c];
      @(negedge clk);
    end
    hit_i = '0;
    exp = (expect_fire < 0) ? int'(predict(n)) : expect_fire;
    @(negedge clk);
    chk(trig_o, 0, {req, " early edge"});
    @(negedge clk);
    chk(trig_o, exp, req);
    @(negedge clk);
    chk(trig_o, 0, {req, " R8 pulse width"});
  endtask

  // window followed by a write d cycles after its last edge (R9)
  task automatic run_flush(input int n, input int d);
    for (int c = 0; c < n; c++) begin
      hit_i = stim[c];
      @(negedge clk);
    end
    hit_i = '0;
    for (int e = 1; e <= 3; e++) begin
      cfg_we = (e == d);
      @(negedge clk);
      cfg_we = 1'b0;
      chk(trig_o, 0, "R9 flush by write");
    end
  endtask

  task automatic all_stn(input int c, input int h);
    for (int s = 0; s < 4; s++) stim[c][h*4+s] = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    rst_n = 1'b0; cfg_we = 1'b0; hit_i = '0;
    cfg_win_len = '0; cfg_stn_req = '0; cfg_hit_min = '0;
    cfg_trk_thr = '0; cfg_or_mode = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(trig_o, 0, "R11 reset trigger low");
    chk(dbg_stn_req_o, 3, "R11 reset requirement 3");

    // R1: hits only in the final window clock are counted
    clr_stim(); all_stn(5, 0);
    cfg_write(6, 4, 1, 1, 0);
    run_win(6, 1, "R1 last-clock hits");
    // R1: counters cleared per window (same config, no hits)
    clr_stim();
    cfg_write(6, 4, 1, 1, 0);
    run_win(6, 0, "R1 fresh window empty");

    // R2: length 5 honoured; length 1 treated as 2
    clr_stim(); all_stn(4, 3);
    cfg_write(5, 4, 1, 1, 0);
    run_win(5, 1, "R2 window of 5");
    clr_stim(); all_stn(0, 3);
    cfg_write(1, 4, 1, 1, 0);
    run_win(2, 1, "R2 length 1 clamped to 2");

    // R3: ten hits saturate at 7, reaching hit_min 7
    clr_stim();
    for (int c = 0; c < 10; c++) all_stn(c, 2);
    cfg_write(10, 4, 7, 1, 0);
    run_win(10, 1, "R3 saturation");

    // R4: three of four stations
    clr_stim();
    for (int s = 0; s < 3; s++) stim[0][4*4+s] = 1'b1;
    cfg_write(6, 3, 1, 1, 0);
    run_win(6, 1, "R4 three of four");
    cfg_write(6, 4, 1, 1, 0);
    run_win(6, 0, "R4 four required");

    // R5: one hit per station, hit_min 3
    clr_stim(); all_stn(1, 6);
    cfg_write(6, 3, 3, 1, 0);
    run_win(6, 0, "R5 AND mode");
    cfg_write(6, 3, 3, 1, 1);
    run_win(6, 1, "R5 OR mode");

    // R6: both halves of sector 0 yield one track
    clr_stim(); all_stn(2, 0); all_stn(2, 1);
    cfg_write(7, 3, 1, 1, 0);
    run_win(7, 1, "R6 one sector one track");
    cfg_write(7, 3, 1, 2, 0);
    run_win(7, 0, "R6 no double count");

    // R7: five sectors against thresholds 5 and 6
    clr_stim();
    for (int k = 0; k < 5; k++) all_stn(3, 2*k + (k % 2));
    cfg_write(7, 3, 1, 5, 0);
    run_win(7, 1, "R7 threshold met");
    cfg_write(7, 3, 1, 6, 0);
    run_win(7, 0, "R7 threshold missed");

    // R9: a write one or two cycles after the window kills the pulse
    clr_stim(); all_stn(0, 5);
    cfg_write(6, 3, 1, 1, 0);
    run_flush(6, 1);
    cfg_write(6, 3, 1, 1, 0);
    run_flush(6, 2);

    // random windows, expectations from predict()
    for (int it = 0; it < 60; it++) begin
      int n, dens;
      n = 2 + int'($urandom % 11);
      dens = int'($urandom % 3);
      clr_stim();
      for (int c = 0; c < n; c++) begin
        stim[c] = {$urandom, $urandom};
        for (int r = 0; r <= dens; r++) stim[c] = stim[c] & {$urandom, $urandom};
      end
      cfg_write(n, 1 + int'($urandom % 4), int'($urandom % 8),
                int'($urandom % 9), 1'($urandom));
      run_win(n, -1, "R1 R4 R5 R6 R7 random window");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule